// File: doc/BRIEF.md
# I2C Register-Bank Target with Shared Auto-Increment Pointer

This block is an I2C target that gives a bus master access to a small bank of 8-bit control registers. It listens on open-drain SCL and SDA lines. It pulls SDA low through `sda_oe` to acknowledge and to send read data, and it only samples the two lines otherwise. The device address is a fixed 7-bit parameter.

A write transaction carries a register-address byte followed by any number of data bytes. A read transaction returns bytes starting at an internal pointer. Reads and writes share this one pointer, and it keeps its value from one transaction to the next. As a result, a read with no address phase continues where the last access stopped. A random read sets the pointer with a short write (device address plus register address only), then issues a repeated start and reads. The pointer steps after every data byte. It wraps from the last implemented register back to 00h.

A host-side port lets surrounding logic (or a bench) load and inspect the registers directly, without using the bus.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, `sda_oe` is 0, every register reads 00h, and the pointer is 00h.
- R2: The first byte after a start is the 7-bit device address (MSB first) followed by a direction bit (bit 0: 1 = read, 0 = write). On a match, the target pulls SDA low during the ninth clock.
- R3: On a device-address mismatch, the target never pulls SDA low and changes no register until the next start or stop.
- R4: In a write, the first byte after the address acknowledge loads its low PTR_W bits into the pointer. Each later byte is stored at the pointer and acknowledged, and the pointer then advances.
- R5: The pointer advances from NUM_REGS-1 (24h by default) to 00h. From any other value it advances by one modulo 2^PTR_W, so an address written above 24h counts up to 3Fh and then to 00h.
- R6: A read with no preceding register-address phase starts at the current pointer, which is left as set by earlier transactions. Each byte sent advances the pointer.
- R7: A write of only a register address, followed by a repeated start (no stop) and a read address, returns data starting at that register.
- R8: Read bytes are sent MSB first. While the master acknowledges, the next sequential register follows. After a master NACK, SDA stays released until the next start or stop.
- R9: The target changes SDA only while SCL is low, and it releases SDA during the master's acknowledge bit.
- R10: A start or stop in the middle of a byte discards the partial byte. The pointer keeps its value.
- R11: A `host_we` pulse stores `host_wdata` at `host_addr`. `host_rdata` shows the register at `host_addr` without latency. An address with no register reads 00h, and a bus write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| host_we | input | 1 | Host write strobe |
| host_addr | input | PTR_W (6) | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The bench builds the block with its defaults: device address 1Ah, 37 registers, a 6-bit pointer and two synchronizer stages. With a 6-bit pointer over 37 registers, the unimplemented addresses 25h to 3Fh can be reached. Both wrap paths can therefore be exercised: 24h to 00h, and 3Fh to 00h for an address written out of range. Two synchronizer stages against an SCL quarter-period of eight clocks leave the target's SDA updates well inside the low phase. Random bursts of writes, current reads and random reads, with random lengths and start addresses, then hit the wrap point repeatedly while carrying the pointer across transactions.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_DEVACK,
      ST_REGADR,
      ST_REGACK,
      ST_WRBYTE,
      ST_WRACK,
      ST_RDBYTE,
      ST_RDACK,
      ST_IGNORE
   } rb_state_e;

   localparam int unsigned RB_DW = 8;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b1;
            else        chain_q <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign q_o    = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
   parameter int NUM_REGS = 37,
   parameter int AW       = 6,
   parameter int DW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata
);
   localparam int FLAT_W = NUM_REGS * DW;

   logic [FLAT_W-1:0] flat;

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [DW-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               val_q <= '0;
            else if (bus_we && bus_addr == AW'(g))
               val_q <= bus_wdata;
            else if (host_we && host_addr == AW'(g))
               val_q <= host_wdata;
         end
         assign flat[g*DW +: DW] = val_q;
      end
   endgenerate

   always_comb begin
      bus_rdata  = '0;
      host_rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (bus_addr == AW'(i))  bus_rdata  = flat[i*DW +: DW];
         if (host_addr == AW'(i)) host_rdata = flat[i*DW +: DW];
      end
   end
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
   import i2c_rb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h1A,
   parameter int         AW       = 6,
   parameter int         NUM_REGS = 37
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_q,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_q,
   input  logic          sda_rise,
   input  logic          sda_fall,
   input  logic [7:0]    rd_data,
   output logic          sda_oe,
   output logic [AW-1:0] ptr_o,
   output logic          wr_stb,
   output logic [7:0]    wr_data,
   output logic          ptr_adv,
   output logic          ptr_load,
   output logic          quiet
);
   localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

   rb_state_e     state_q;
   logic [3:0]    cnt_q;
   logic [7:0]    rx_q;
   logic [7:0]    tx_q;
   logic          rw_q;
   logic          mack_q;
   logic [AW-1:0] ptr_q;

   logic ev_start, ev_stop, byte_full, load_rd;

   function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
      return (p == LAST) ? '0 : p + AW'(1);
   endfunction

   assign ev_start  = scl_q & sda_fall;
   assign ev_stop   = scl_q & sda_rise;
   assign byte_full = (cnt_q == 4'd8);

   assign wr_stb   = scl_fall && state_q == ST_WRBYTE && byte_full;
   assign ptr_load = scl_fall && state_q == ST_REGADR && byte_full;
   assign load_rd  = scl_fall && ((state_q == ST_DEVACK && rw_q) ||
                                  (state_q == ST_RDACK && mack_q));
   assign ptr_adv  = wr_stb | load_rd;
   assign wr_data  = rx_q;
   assign ptr_o    = ptr_q;
   assign quiet    = (state_q == ST_IDLE) || (state_q == ST_IGNORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         ptr_q   <= '0;
         sda_oe  <= 1'b0;
      end else if (ev_start) begin
         state_q <= ST_DEVADR;
         cnt_q   <= '0;
         sda_oe  <= 1'b0;
      end else if (ev_stop) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sda_oe  <= 1'b0;
      end else if (scl_rise) begin
         case (state_q)
            ST_DEVADR, ST_REGADR, ST_WRBYTE: begin
               if (!byte_full) begin
                  rx_q  <= {rx_q[6:0], sda_q};
                  cnt_q <= cnt_q + 4'd1;
               end
            end
            ST_RDBYTE: if (!byte_full) cnt_q <= cnt_q + 4'd1;
            ST_RDACK:  mack_q <= ~sda_q;
            default: ;
         endcase
      end else if (scl_fall) begin
         case (state_q)
            ST_DEVADR: begin
               if (byte_full) begin
                  if (rx_q[7:1] == DEV_ADDR) begin
                     rw_q    <= rx_q[0];
                     sda_oe  <= 1'b1;
                     state_q <= ST_DEVACK;
                  end else begin
                     state_q <= ST_IGNORE;
                  end
               end
            end
            ST_DEVACK: begin
               cnt_q <= '0;
               if (rw_q) begin
                  tx_q    <= rd_data;
                  sda_oe  <= ~rd_data[7];
                  ptr_q   <= step_ptr(ptr_q);
                  state_q <= ST_RDBYTE;
               end else begin
                  sda_oe  <= 1'b0;
                  state_q <= ST_REGADR;
               end
            end
            ST_REGADR: begin
               if (byte_full) begin
                  ptr_q   <= rx_q[AW-1:0];
                  sda_oe  <= 1'b1;
                  state_q <= ST_REGACK;
               end
            end
            ST_REGACK, ST_WRACK: begin
               sda_oe  <= 1'b0;
               cnt_q   <= '0;
               state_q <= ST_WRBYTE;
            end
            ST_WRBYTE: begin
               if (byte_full) begin
                  sda_oe  <= 1'b1;
                  ptr_q   <= step_ptr(ptr_q);
                  state_q <= ST_WRACK;
               end
            end
            ST_RDBYTE: begin
               if (byte_full) begin
                  sda_oe  <= 1'b0;
                  state_q <= ST_RDACK;
               end else begin
                  tx_q   <= {tx_q[6:0], 1'b0};
                  sda_oe <= ~tx_q[6];
               end
            end
            ST_RDACK: begin
               cnt_q <= '0;
               if (mack_q) begin
                  tx_q    <= rd_data;
                  sda_oe  <= ~rd_data[7];
                  ptr_q   <= step_ptr(ptr_q);
                  state_q <= ST_RDBYTE;
               end else begin
                  state_q <= ST_IGNORE;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h1A,
   parameter int         NUM_REGS    = 37,
   parameter int         PTR_W       = 6,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             host_we,
   input  logic [PTR_W-1:0] host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata
);
   localparam int DW = i2c_rb_pkg::RB_DW;

   generate
      if (NUM_REGS < 2 || NUM_REGS > (1 << PTR_W)) begin : g_bad_depth
         $error("NUM_REGS must lie between 2 and 2**PTR_W");
      end
      if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
         $error("PTR_W must lie between 1 and 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic             scl_q, scl_rise, scl_fall;
   logic             sda_q, sda_rise, sda_fall;
   logic [DW-1:0]    bus_rdata, bus_wdata;
   logic [PTR_W-1:0] bus_ptr;
   logic             bus_we, ptr_adv, ptr_load, eng_quiet;

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i),
      .q_o(scl_q), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i),
      .q_o(sda_q), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   i2c_rb_engine #(.DEV_ADDR(DEV_ADDR), .AW(PTR_W), .NUM_REGS(NUM_REGS)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_q(sda_q), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .rd_data(bus_rdata), .sda_oe(sda_oe), .ptr_o(bus_ptr),
      .wr_stb(bus_we), .wr_data(bus_wdata),
      .ptr_adv(ptr_adv), .ptr_load(ptr_load), .quiet(eng_quiet)
   );

   i2c_rb_regs #(.NUM_REGS(NUM_REGS), .AW(PTR_W), .DW(DW)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_ptr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
   parameter int PTR_W    = 6,
   parameter int NUM_REGS = 37
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_oe,
   input logic [PTR_W-1:0] ptr,
   input logic             ptr_adv,
   input logic             ptr_load,
   input logic             wr_stb,
   input logic             quiet
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   // R9: SDA drive only moves while SCL is low
   a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);

   // R5: wrap from the last register
   a_r5_wrap_last: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_adv && ptr == LAST) |=> (ptr == '0));

   // R5: plain step elsewhere
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_adv && ptr != LAST) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

   // R10: pointer holds without a load or advance
   a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_adv && !ptr_load) |=> $stable(ptr));

   // R4: each stored byte is acknowledged
   a_r4_ack_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> sda_oe);

   // R3: idle or ignoring leaves SDA released
   a_r3_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> !sda_oe);
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.PTR_W(PTR_W), .NUM_REGS(NUM_REGS)) i_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .ptr(bus_ptr),
   .ptr_adv(ptr_adv), .ptr_load(ptr_load), .wr_stb(bus_we), .quiet(eng_quiet)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;
   localparam logic [6:0] DEV  = 7'h1A;
   localparam int         NREG = 37;
   localparam int         Q    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_oe;
   logic       host_we = 1'b0;
   logic [5:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   wire        sda_line = ~(m_low | sda_oe);

   int         checks = 0;
   int         bad = 0;
   int         r9_viol = 0;
   logic [7:0] model [NREG];
   logic [5:0] mptr = '0;
   logic [7:0] wbuf [8];

   always #2 clk = ~clk;

   i2c_regbank_target i_i2c_regbank_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   // R9 monitor: drive changes seen while SCL is high
   logic prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_oe !== prev_oe && scl) r9_viol++;
      prev_oe <= sda_oe;
   end

   function automatic logic [5:0] nxt(input logic [5:0] p);
      return (p == 6'(NREG - 1)) ? 6'd0 : p + 6'd1;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [5:0] p);
      if (int'(p) < NREG) return model[p];
      return 8'h00;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(input bit b);
      m_low = !b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
   endtask

   task automatic get_bit(output bit b);
      m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(s);
      ack = !s;
   endtask

   task automatic get_byte(input bit ack_it, output logic [7:0] v);
      bit s;
      for (int i = 7; i >= 0; i--) begin get_bit(s); v[i] = s; end
      put_bit(!ack_it);
   endtask

   task automatic bus_start();
      m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic bus_rstart();
      m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(2*Q);
   endtask

   task automatic host_wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk); host_we = 1'b0;
      if (int'(a) < NREG) model[a] = d;
   endtask

   task automatic host_chk(input string req, input logic [5:0] a);
      @(negedge clk); host_addr = a; #1;
      chk(req, host_rdata, exp_rd(a));
   endtask

   task automatic bus_write(input logic [5:0] a, input int n);
      bit ack;
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk("R2 write address ack", ack, 1);
      send_byte({2'b00, a}, ack);  chk("R4 register address ack", ack, 1);
      mptr = a;
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], ack); chk("R4 data ack", ack, 1);
         if (int'(mptr) < NREG) model[mptr] = wbuf[k];
         mptr = nxt(mptr);
      end
      bus_stop();
   endtask

   task automatic read_run(input int n, input string req);
      logic [7:0] v;
      for (int k = 0; k < n; k++) begin
         get_byte(k < n - 1, v);
         chk(req, v, exp_rd(mptr));
         mptr = nxt(mptr);
      end
      bus_stop();
   endtask

   task automatic cur_read(input int n);
      bit ack;
      bus_start();
      send_byte({DEV, 1'b1}, ack); chk("R2 read address ack", ack, 1);
      read_run(n, "R6 current read data");
   endtask

   task automatic rand_read(input logic [5:0] a, input int n);
      bit ack;
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk("R7 dummy write ack", ack, 1);
      send_byte({2'b00, a}, ack);  chk("R7 register address ack", ack, 1);
      bus_rstart();
      send_byte({DEV, 1'b1}, ack); chk("R7 read address after repeated start", ack, 1);
      mptr = a;
      read_run(n, "R7 R8 random read data");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      bit ack, s;
      logic [7:0] v;
      void'($urandom(32'd1234));
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      wq(5);
      chk("R1 sda released in reset", sda_oe, 0);
      rst_n = 1'b1;
      wq(5);
      chk("R1 sda released after reset", sda_oe, 0);
      for (int i = 0; i < NREG; i++) host_chk("R1 register reset value", 6'(i));

      // R11 host port
      host_wr(6'd5, 8'hA5);
      host_chk("R11 host write readback", 6'd5);
      host_wr(6'd40, 8'h77);
      host_chk("R11 unimplemented address reads zero", 6'd40);

      // R4 burst write
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      bus_write(6'd3, 4);
      for (int i = 3; i < 7; i++) host_chk("R4 burst write stored", 6'(i));

      // R6 current read continues at 7
      host_wr(6'd7, 8'h5C); host_wr(6'd8, 8'hC3);
      cur_read(2);

      // R7 random read
      rand_read(6'd3, 3);

      // R5 write across the wrap
      wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
      bus_write(6'd35, 3);
      host_chk("R5 write at 23h", 6'd35);
      host_chk("R5 write at 24h", 6'd36);
      host_chk("R5 write wrapped to 00h", 6'd0);
      rand_read(6'd34, 4);

      // R5 out-of-range address counts to 3Fh then 00h
      rand_read(6'h3E, 3);

      // R11 bus write to unimplemented address is dropped
      wbuf[0] = 8'h99;
      bus_write(6'd50, 1);
      host_chk("R11 bus write to missing register", 6'd50);

      // R3 address mismatch
      host_wr(6'd2, 8'h3D);
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b0}, ack); chk("R3 no ack on mismatch", ack, 0);
      send_byte(8'h02, ack); chk("R3 no ack while ignoring", ack, 0);
      send_byte(8'hFF, ack); chk("R3 no ack on later byte", ack, 0);
      bus_stop();
      host_chk("R3 register untouched", 6'd2);

      // R8 NACK releases the line
      bus_start();
      send_byte({DEV, 1'b1}, ack); chk("R8 read address ack", ack, 1);
      get_byte(1'b0, v); chk("R8 byte before nack", v, exp_rd(mptr));
      mptr = nxt(mptr);
      get_bit(s); chk("R8 line released after nack", s, 1);
      bus_stop();

      // R10 abort mid-byte by repeated start
      host_wr(6'd10, 8'h6B);
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk("R10 address ack", ack, 1);
      send_byte(8'd10, ack);       chk("R10 register address ack", ack, 1);
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      bus_rstart();
      send_byte({DEV, 1'b1}, ack); chk("R10 read after abort ack", ack, 1);
      mptr = 6'd10;
      read_run(1, "R10 partial byte discarded pointer kept");
      host_chk("R10 register unchanged", 6'd10);

      // mixed random traffic
      for (int t = 0; t < 22; t++) begin
         int op, n;
         op = int'($urandom % 3);
         n  = 1 + int'($urandom % 5);
         if (op == 0) begin
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            bus_write(6'($urandom % 40), n);
         end else if (op == 1) begin
            cur_read(n);
         end else begin
            rand_read(6'($urandom % 64), n);
         end
      end
      for (int i = 0; i < NREG; i++) host_chk("R4 R11 final register image", 6'(i));

      chk("R9 sda changed while SCL high", r9_viol, 0);

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule